// File: doc/BRIEF.md
# PC-Relative Add and Register-Indirect Jump Execute Stage

This block is the execute slice of a RISC-V integer pipeline that handles two instructions: AUIPC, which adds an upper immediate to the program counter, and JALR, which jumps to a register-plus-offset target and links. Each cycle it takes the 32-bit instruction word, the address of that instruction and the rs1 operand value. It decodes the opcode and the immediates itself. One clock later it presents a destination index, a write-back value with its enable, and a redirect request with its target.

The PC each instruction sees is always the address of the instruction itself. For AUIPC that PC is never masked. For JALR the link value is that PC plus four, and the jump target always has its least significant bit cleared. When the core has no compressed-instruction support, a JALR target that is only halfword aligned raises a misalignment flag in place of the jump. Any other instruction word leaves every output at zero.

Top module: `pcrel_jump_exec`

## Requirements
- R1: For opcode 7'b0010111 (AUIPC), the write-back value is the instruction's own PC plus instr[31:12] shifted left by 12. That 32-bit offset is sign-extended to XLEN before the add, so an offset with bit 31 set lowers the result. redirect_o stays 0 and target_o is 0.
- R2: AUIPC applies no mask to the PC. Bits [11:0] of its write-back value equal bits [11:0] of pc_i.
- R3: For opcode 7'b1100111 with instr[14:12] = 3'b000 (JALR), the target is rs1_val_i plus the sign-extended 12-bit instr[31:20], with bit 0 of the sum forced to 0. When the target is aligned, redirect_o is 1.
- R4: JALR writes pc_i + 4 (modulo 2^XLEN), computed from the jump's own PC, as its write-back value.
- R5: When instr[11:7] is 0, wb_en_o is 0 for both instructions. A JALR to x0 still asserts redirect_o.
- R6: The target uses the rs1_val_i presented with the JALR even when the rd and rs1 fields name the same register. The link value never feeds the target.
- R7: Any other opcode, or opcode 7'b1100111 with a nonzero instr[14:12], drives rd_idx_o, wb_val_o, wb_en_o, redirect_o, target_o and misalign_o to 0.
- R8: With SUPPORT_C = 0, a JALR whose cleared target has bit 1 set raises misalign_o, holds redirect_o and wb_en_o at 0, and still shows the target on target_o. With SUPPORT_C = 1, misalign_o is never raised.
- R9: All outputs are registered. The result for inputs sampled at one rising edge appears after that edge. While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word being executed |
| pc_i | input | XLEN | Address of that instruction |
| rs1_val_i | input | XLEN | Value read for the rs1 field |
| rd_idx_o | output | 5 | Destination register index |
| wb_val_o | output | XLEN | Value to write back |
| wb_en_o | output | 1 | Write-back enable |
| redirect_o | output | 1 | Fetch redirect request |
| target_o | output | XLEN | Redirect target address |
| misalign_o | output | 1 | Jump target not word aligned |

## Verification
The stage keeps no state beyond its output register, so any internal fault appears at the ports one cycle after the offending instruction and persists no further. A wrong decode shows up as a spurious enable or redirect on an unrelated opcode. A wrong immediate or PC choice shows up as an off-by-four or an off-by-4096 result, and a masked PC shows up as altered low bits of an AUIPC result. A lost bit-0 clear appears as an odd target, and a misalignment fault appears as a redirect and a write that both occur in the same cycle as the flag.

// File: rtl/pcrel_jump_pkg.sv
package pcrel_jump_pkg;

   localparam int ILEN       = 32;
   localparam int REG_IDX_W  = 5;
   localparam int IMM_U_LSB  = 12;
   localparam int IMM_I_W    = 12;

   localparam logic [6:0] OPC_AUIPC = 7'b0010111;
   localparam logic [6:0] OPC_JALR  = 7'b1100111;
   localparam logic [2:0] F3_JALR   = 3'b000;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_AUIPC = 2'd1,
      KIND_JALR  = 2'd2
   } exec_kind_e;

   typedef struct packed {
      exec_kind_e             kind;
      logic [REG_IDX_W-1:0]   rd;
      logic [ILEN-1:0]        imm_u;
      logic [ILEN-1:0]        imm_i;
   } decoded_t;

endpackage

// File: rtl/pcrel_jump_decode.sv
module pcrel_jump_decode
   import pcrel_jump_pkg::*;
(
   input  logic [ILEN-1:0] instr,
   output decoded_t        dec
);

   logic [6:0] opcode;
   logic [2:0] funct3;

   assign opcode = instr[6:0];
   assign funct3 = instr[14:12];

   always_comb begin
      dec.kind = KIND_NONE;
      if (opcode == OPC_AUIPC) begin
         dec.kind = KIND_AUIPC;
      end else if ((opcode == OPC_JALR) && (funct3 == F3_JALR)) begin
         dec.kind = KIND_JALR;
      end
   end

   assign dec.rd    = instr[11:7];
   assign dec.imm_u = {instr[ILEN-1:IMM_U_LSB], {IMM_U_LSB{1'b0}}};
   assign dec.imm_i = {{(ILEN-IMM_I_W){instr[ILEN-1]}}, instr[ILEN-1:ILEN-IMM_I_W]};

endmodule

// File: rtl/pcrel_jump_sext.sv
module pcrel_jump_sext #(
   parameter int IN_W  = 32,
   parameter int OUT_W = 64
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);

   if (OUT_W < IN_W) begin : g_bad_width
      $error("pcrel_jump_sext: OUT_W must not be below IN_W");
   end

   if (OUT_W > IN_W) begin : g_widen
      assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
   end else begin : g_same
      assign dout = din[OUT_W-1:0];
   end

endmodule

// File: rtl/pcrel_jump_addr.sv
module pcrel_jump_addr
   import pcrel_jump_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit SUPPORT_C = 1'b0
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [ILEN-1:0] imm_u,
   input  logic [ILEN-1:0] imm_i,
   output logic [XLEN-1:0] upper_sum,
   output logic [XLEN-1:0] link_val,
   output logic [XLEN-1:0] jump_tgt,
   output logic            tgt_misaligned
);

   localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(ILEN / 8);
   localparam logic [XLEN-1:0] LSB_CLEAR   = ~XLEN'(1);

   logic [XLEN-1:0] imm_u_x;
   logic [XLEN-1:0] imm_i_x;
   logic [XLEN-1:0] jump_sum;

   pcrel_jump_sext #(.IN_W(ILEN), .OUT_W(XLEN)) u_sext_u (
      .din  (imm_u),
      .dout (imm_u_x)
   );

   pcrel_jump_sext #(.IN_W(ILEN), .OUT_W(XLEN)) u_sext_i (
      .din  (imm_i),
      .dout (imm_i_x)
   );

   assign upper_sum = pc + imm_u_x;
   assign link_val  = pc + INSTR_BYTES;
   assign jump_sum  = rs1_val + imm_i_x;
   assign jump_tgt  = jump_sum & LSB_CLEAR;

   if (SUPPORT_C) begin : g_halfword_ok
      assign tgt_misaligned = 1'b0;
   end else begin : g_word_only
      assign tgt_misaligned = jump_tgt[1];
   end

endmodule

// File: rtl/pcrel_jump_outreg.sv
module pcrel_jump_outreg
   import pcrel_jump_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REG_IDX_W-1:0] rd_d,
   input  logic [XLEN-1:0]      wb_d,
   input  logic                 en_d,
   input  logic                 redir_d,
   input  logic [XLEN-1:0]      tgt_d,
   input  logic                 mis_d,
   output logic [REG_IDX_W-1:0] rd_q,
   output logic [XLEN-1:0]      wb_q,
   output logic                 en_q,
   output logic                 redir_q,
   output logic [XLEN-1:0]      tgt_q,
   output logic                 mis_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= '0;
         wb_q    <= '0;
         en_q    <= 1'b0;
         redir_q <= 1'b0;
         tgt_q   <= '0;
         mis_q   <= 1'b0;
      end else begin
         rd_q    <= rd_d;
         wb_q    <= wb_d;
         en_q    <= en_d;
         redir_q <= redir_d;
         tgt_q   <= tgt_d;
         mis_q   <= mis_d;
      end
   end

endmodule

// File: rtl/pcrel_jump_exec.sv
module pcrel_jump_exec
   import pcrel_jump_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit SUPPORT_C = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ILEN-1:0]      instr_i,
   input  logic [XLEN-1:0]      pc_i,
   input  logic [XLEN-1:0]      rs1_val_i,
   output logic [REG_IDX_W-1:0] rd_idx_o,
   output logic [XLEN-1:0]      wb_val_o,
   output logic                 wb_en_o,
   output logic                 redirect_o,
   output logic [XLEN-1:0]      target_o,
   output logic                 misalign_o
);

   if ((XLEN != 32) && (XLEN != 64)) begin : g_bad_xlen
      $error("pcrel_jump_exec: XLEN must be 32 or 64");
   end

   decoded_t             dec;
   logic [XLEN-1:0]      upper_sum;
   logic [XLEN-1:0]      link_val;
   logic [XLEN-1:0]      jump_tgt;
   logic                 tgt_mis;

   logic [REG_IDX_W-1:0] nx_rd;
   logic [XLEN-1:0]      nx_wb;
   logic                 nx_en;
   logic                 nx_redir;
   logic [XLEN-1:0]      nx_tgt;
   logic                 nx_mis;
   logic                 rd_live;

   pcrel_jump_decode u_dec (
      .instr (instr_i),
      .dec   (dec)
   );

   pcrel_jump_addr #(.XLEN(XLEN), .SUPPORT_C(SUPPORT_C)) u_addr (
      .pc             (pc_i),
      .rs1_val        (rs1_val_i),
      .imm_u          (dec.imm_u),
      .imm_i          (dec.imm_i),
      .upper_sum      (upper_sum),
      .link_val       (link_val),
      .jump_tgt       (jump_tgt),
      .tgt_misaligned (tgt_mis)
   );

   assign rd_live = (dec.rd != '0);

   always_comb begin
      nx_rd    = '0;
      nx_wb    = '0;
      nx_en    = 1'b0;
      nx_redir = 1'b0;
      nx_tgt   = '0;
      nx_mis   = 1'b0;
      case (dec.kind)
         KIND_AUIPC: begin
            nx_rd = dec.rd;
            nx_wb = upper_sum;
            nx_en = rd_live;
         end
         KIND_JALR: begin
            nx_rd  = dec.rd;
            nx_wb  = link_val;
            nx_tgt = jump_tgt;
            if (tgt_mis) begin
               nx_mis = 1'b1;
            end else begin
               nx_redir = 1'b1;
               nx_en    = rd_live;
            end
         end
         default: begin
         end
      endcase
   end

   pcrel_jump_outreg #(.XLEN(XLEN)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_d    (nx_rd),
      .wb_d    (nx_wb),
      .en_d    (nx_en),
      .redir_d (nx_redir),
      .tgt_d   (nx_tgt),
      .mis_d   (nx_mis),
      .rd_q    (rd_idx_o),
      .wb_q    (wb_val_o),
      .en_q    (wb_en_o),
      .redir_q (redirect_o),
      .tgt_q   (target_o),
      .mis_q   (misalign_o)
   );

endmodule

// File: rtl/pcrel_jump_exec_chk.sv
module pcrel_jump_exec_chk
   import pcrel_jump_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit SUPPORT_C = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ILEN-1:0]      instr_i,
   input logic [XLEN-1:0]      pc_i,
   input logic [XLEN-1:0]      rs1_val_i,
   input logic [REG_IDX_W-1:0] rd_idx_o,
   input logic [XLEN-1:0]      wb_val_o,
   input logic                 wb_en_o,
   input logic                 redirect_o,
   input logic [XLEN-1:0]      target_o,
   input logic                 misalign_o
);

   logic armed;
   logic in_auipc;
   logic in_jalr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign in_auipc = (instr_i[6:0] == OPC_AUIPC);
   assign in_jalr  = (instr_i[6:0] == OPC_JALR) && (instr_i[14:12] == F3_JALR);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (!wb_en_o && !redirect_o && !misalign_o && (wb_val_o == '0))); // R9

   AST_AUIPC_PC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_auipc)) |-> ((wb_val_o[11:0] == $past(pc_i[11:0])) && !redirect_o)); // R2

   AST_TARGET_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> !target_o[0]); // R3

   AST_LINK_IS_PC4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && redirect_o) |-> (wb_val_o == $past(pc_i) + XLEN'(4))); // R4

   AST_X0_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> (rd_idx_o != '0)); // R5

   AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(in_auipc) && !$past(in_jalr)) |-> (!wb_en_o && !redirect_o && !misalign_o)); // R7

   AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> (!redirect_o && !wb_en_o)); // R8

   if (SUPPORT_C) begin : g_chk_c
      AST_NO_MISALIGN_WITH_C: assert property (@(posedge clk) disable iff (!rst_n)
         !misalign_o); // R8
   end else begin : g_chk_noc
      AST_MISALIGN_TRACKS_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_jalr)) |-> (misalign_o == target_o[1])); // R8
   end

endmodule

bind pcrel_jump_exec pcrel_jump_exec_chk #(.XLEN(XLEN), .SUPPORT_C(SUPPORT_C)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr_i    (instr_i),
   .pc_i       (pc_i),
   .rs1_val_i  (rs1_val_i),
   .rd_idx_o   (rd_idx_o),
   .wb_val_o   (wb_val_o),
   .wb_en_o    (wb_en_o),
   .redirect_o (redirect_o),
   .target_o   (target_o),
   .misalign_o (misalign_o)
);

// File: tb/sim_pcrel_jump_exec.sv
`timescale 1ns/1ps
module sim_pcrel_jump_exec;

   typedef struct {
      logic [4:0]  rd;
      logic [31:0] wb;
      logic        en;
      logic        redir;
      logic [31:0] tgt;
      logic        mis;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr_i = 32'h0;
   logic [31:0] pc_i = 32'h0;
   logic [31:0] rs1_val_i = 32'h0;
   logic [4:0]  rd_idx_o;
   logic [31:0] wb_val_o;
   logic        wb_en_o;
   logic        redirect_o;
   logic [31:0] target_o;
   logic        misalign_o;

   int   checks = 0;
   int   errors = 0;
   exp_t sbq[$];

   always #2 clk = ~clk;

   pcrel_jump_exec #(.XLEN(32), .SUPPORT_C(1'b0)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_i    (instr_i),
      .pc_i       (pc_i),
      .rs1_val_i  (rs1_val_i),
      .rd_idx_o   (rd_idx_o),
      .wb_val_o   (wb_val_o),
      .wb_en_o    (wb_en_o),
      .redirect_o (redirect_o),
      .target_o   (target_o),
      .misalign_o (misalign_o)
   );

   function automatic logic [31:0] enc_auipc(input logic [4:0] rd, input logic [19:0] imm);
      return {imm, rd, 7'b0010111};
   endfunction

   function automatic logic [31:0] enc_jalr(input logic [4:0] rd, input logic [4:0] rs1,
                                           input logic [11:0] imm);
      return {imm, rs1, 3'b000, rd, 7'b1100111};
   endfunction

   function automatic exp_t model(input logic [31:0] ins, input logic [31:0] pc,
                                  input logic [31:0] rs1, input string tag);
      exp_t        e;
      logic [31:0] sum;
      e.rd = 5'd0; e.wb = 32'h0; e.en = 1'b0; e.redir = 1'b0; e.tgt = 32'h0; e.mis = 1'b0;
      e.tag = tag;
      if (ins[6:0] == 7'b0010111) begin
         e.rd = ins[11:7];
         e.wb = pc + {ins[31:12], 12'h000};
         e.en = (ins[11:7] != 5'd0);
      end else if (ins[6:0] == 7'b1100111 && ins[14:12] == 3'b000) begin
         sum   = rs1 + {{20{ins[31]}}, ins[31:20]};
         e.rd  = ins[11:7];
         e.wb  = pc + 32'd4;
         e.tgt = {sum[31:1], 1'b0};
         if (e.tgt[1]) begin
            e.mis = 1'b1;
         end else begin
            e.redir = 1'b1;
            e.en    = (ins[11:7] != 5'd0);
         end
      end
      return e;
   endfunction

   task automatic send(input logic [31:0] ins, input logic [31:0] pc,
                       input logic [31:0] rs1, input string tag);
      @(negedge clk);
      instr_i   = ins;
      pc_i      = pc;
      rs1_val_i = rs1;
      sbq.push_back(model(ins, pc, rs1, tag));
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         checks++;
         if (rd_idx_o !== e.rd || wb_val_o !== e.wb || wb_en_o !== e.en ||
             redirect_o !== e.redir || target_o !== e.tgt || misalign_o !== e.mis) begin
            errors++;
            $display("FAIL %s: got rd=%0d wb=%h en=%b redir=%b tgt=%h mis=%b, expected rd=%0d wb=%h en=%b redir=%b tgt=%h mis=%b",
                     e.tag, rd_idx_o, wb_val_o, wb_en_o, redirect_o, target_o, misalign_o,
                     e.rd, e.wb, e.en, e.redir, e.tgt, e.mis);
         end
      end
   end

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      instr_i   = enc_jalr(5'd1, 5'd2, 12'h004);
      pc_i      = 32'h0000_0100;
      rs1_val_i = 32'h0000_1000;
      repeat (3) @(negedge clk);
      checks++;
      if (rd_idx_o !== 5'd0 || wb_val_o !== 32'h0 || wb_en_o !== 1'b0 ||
          redirect_o !== 1'b0 || target_o !== 32'h0 || misalign_o !== 1'b0) begin
         errors++;
         $display("FAIL R9 reset: got en=%b redir=%b wb=%h tgt=%h, expected all zero",
                  wb_en_o, redirect_o, wb_val_o, target_o);
      end
      rst_n = 1'b1;
      instr_i = 32'h0000_0013;

      send(enc_auipc(5'd5, 20'h12345), 32'h1000_0004, 32'h0, "R1 auipc positive");
      send(enc_auipc(5'd6, 20'hFFFFF), 32'h0000_2ABC, 32'h0, "R1 auipc negative offset");
      send(enc_auipc(5'd7, 20'h80000), 32'h9000_0000, 32'h0, "R1 auipc bit31 offset");
      send(enc_auipc(5'd8, 20'h00001), 32'h8000_0FFE, 32'h0, "R2 auipc low pc bits kept");
      send(enc_jalr(5'd1, 5'd2, 12'h004), 32'h0000_0200, 32'h0000_1000, "R3 R4 jalr basic");
      send(enc_jalr(5'd1, 5'd2, 12'h000), 32'h0000_0300, 32'h0000_1001, "R3 jalr odd sum");
      send(enc_jalr(5'd3, 5'd4, 12'hFFD), 32'h0000_0400, 32'h0000_3000, "R3 jalr negative imm");
      send(enc_jalr(5'd0, 5'd2, 12'h010), 32'h0000_0500, 32'h0000_2000, "R5 jalr to x0 redirects");
      send(enc_auipc(5'd0, 20'h00010), 32'h0000_0600, 32'h0, "R5 auipc to x0");
      send(enc_jalr(5'd7, 5'd7, 12'h008), 32'h0000_0700, 32'h0000_4000, "R6 rd equals rs1");
      send(32'h00A0_0093, 32'h0000_0800, 32'h0000_5000, "R7 other opcode");
      send({12'h004, 5'd2, 3'b001, 5'd1, 7'b1100111}, 32'h0000_0900, 32'h0000_1000,
           "R7 jalr funct3 nonzero");
      send(enc_jalr(5'd1, 5'd2, 12'h000), 32'h0000_0A00, 32'h0000_1002, "R8 misaligned target");
      send(enc_jalr(5'd1, 5'd2, 12'h001), 32'h0000_0B00, 32'h0000_1001, "R8 odd to halfword");
      send(enc_jalr(5'd9, 5'd2, 12'h7FC), 32'hFFFF_FFFC, 32'h0000_0004, "R4 link wraps");
      send(32'h0000_0013, 32'h0, 32'h0, "R7 idle before latency probe");
      send(enc_jalr(5'd2, 5'd3, 12'h000), 32'h0000_0C00, 32'h0000_8000, "R9 registered jalr");
      #1;
      checks++;
      if (redirect_o !== 1'b0) begin
         errors++;
         $display("FAIL R9 latency: got redirect=%b before edge, expected 0", redirect_o);
      end
      send(enc_auipc(5'd4, 20'h00002), 32'h0000_0D00, 32'h0, "R9 back to back auipc");
      send(32'h0000_0013, 32'h0, 32'h0, "R7 trailing idle");

      while (sbq.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule